// File: doc/BRIEF.md
# Quaternary Digit Field Unit

This unit operates on packed vectors of quaternary digits. Each digit is stored as two bits that together name one element of the four-element Galois field. A three-bit opcode selects one operation, and every digit lane applies that operation independently to the matching digits of two operands. Every lane is built only from AND and XOR terms on the component bits, and that includes the ordered comparisons minimum and maximum. None of the lanes contains a magnitude comparator or an integer adder.

An operand pair and an opcode are presented together under a valid/ready handshake. The result is captured in one output register and presented under a second valid/ready pair one cycle after acceptance. The register keeps its contents while the consumer stalls. The input side accepts a new operation in any cycle where the register is empty or is being drained in that same cycle, so the unit sustains one operation per clock.

Top module: `gf4q_unit`

## Requirements
- R1: Digit i of a vector occupies bits [2i+1:2i]. Bit 2i is the unit component and bit 2i+1 is the generator component. Read as a two-bit binary number, the pair gives the quaternary value 0..3, so value 2 is the generator g and value 3 is 1+g.
- R2: Opcode 0 returns the field sum of each digit pair, which is the XOR of the two pairs.
- R3: Opcode 1 returns the field product of each digit pair, using g·g = g+1.
- R4: Opcode 2 returns the field square of each digit of operand A, and operand B has no effect.
- R5: Opcode 3 returns the field cube of each digit of operand A. The cube is 1 for any nonzero digit and 0 for a zero digit, so every generator bit of the result is 0.
- R6: Opcode 4 returns, for each digit, the smaller of the two digits compared as integers 0..3.
- R7: Opcode 5 returns, for each digit, the larger of the two digits compared as integers 0..3.
- R8: Opcode 6 adds the constant 2 and opcode 7 adds the constant 3 to each digit of A, as field sums. Operand B has no effect on either.
- R9: An operation is accepted in a cycle where in_valid and in_ready are both 1. In the next cycle out_valid is 1 and out_data holds its result.
- R10: While out_valid is 1 and out_ready is 0, out_valid and out_data stay unchanged. in_ready is 1 exactly when out_valid is 0 or out_ready is 1.
- R11: A clock edge with rst_n low clears out_valid and out_data to 0.
- R12: When a result is taken (out_valid and out_ready both 1) and no operation is accepted in that cycle, out_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair and opcode are present |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 3 | Operation select (0 add, 1 mul, 2 square, 3 cube, 4 min, 5 max, 6 add 2, 7 add 3) |
| in_a | input | 2*DIGITS | Operand A, packed digits |
| in_b | input | 2*DIGITS | Operand B, packed digits |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 2*DIGITS | Result, packed digits |

## Verification
The situation hardest to reach from the ports is a stalled result register that receives a new operation in the same cycle it is drained. A second case is an operation that arrives while the register is full and not draining, which must be refused without disturbing the held result. Directed passes first send every pair of digit values through every opcode with the output always ready. A long pseudo-random phase then switches in_valid and out_ready independently, so stalls, simultaneous drain-and-load cycles and refused offers all occur many times. Operands in that phase are sometimes forced equal or zero, so the tie paths of minimum and maximum are exercised.

// File: rtl/gf4q_pkg.sv
// Shared types for the quaternary digit field unit.
// Assumes each digit is a packed pair: hi = generator component, lo = unit component.
package gf4q_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_MUL  = 3'd1,
        OP_SQR  = 3'd2,
        OP_CUBE = 3'd3,
        OP_MIN  = 3'd4,
        OP_MAX  = 3'd5,
        OP_ADD2 = 3'd6,
        OP_ADD3 = 3'd7
    } gf4_op_e;

    typedef struct packed {
        logic hi;   // generator component, place value 2
        logic lo;   // unit component, place value 1
    } gf4_digit_t;

endpackage

// File: rtl/gf4q_digit_ops.sv
// One digit lane: computes the selected field operation on a pair of digits.
// Assumes the pair encoding from gf4q_pkg; uses AND/XOR terms only.
module gf4q_digit_ops
    import gf4q_pkg::*;
(
    input  gf4_op_e    op,
    input  gf4_digit_t x,
    input  gf4_digit_t y,
    output gf4_digit_t r
);

    logic x1, x2, y1, y2;
    logic diff_hi;
    logic either_lo;

    assign x1 = x.lo;
    assign x2 = x.hi;
    assign y1 = y.lo;
    assign y2 = y.hi;

    // High components differ: the ordering is then decided by the high bits
    assign diff_hi   = x2 ^ y2;
    // Logical OR of the low bits written in field form
    assign either_lo = x1 ^ y1 ^ (x1 & y1);

    // Operation select over the per-operation polynomials
    always_comb begin
        r = '0;
        unique case (op)
            OP_ADD: begin
                r.lo = x1 ^ y1;
                r.hi = x2 ^ y2;
            end
            OP_MUL: begin
                r.lo = (x1 & y1) ^ (x2 & y2);
                r.hi = (x1 & y2) ^ (x2 & y1) ^ (x2 & y2);
            end
            OP_SQR: begin
                r.lo = x1 ^ x2;
                r.hi = x2;
            end
            OP_CUBE: begin
                r.lo = x1 ^ x2 ^ (x1 & x2);
                r.hi = 1'b0;
            end
            OP_MIN: begin
                r.hi = x2 & y2;
                r.lo = (x1 & y1) ^ (diff_hi & ((x2 & y1) ^ (y2 & x1) ^ (x1 & y1)));
            end
            OP_MAX: begin
                r.hi = x2 ^ y2 ^ (x2 & y2);
                r.lo = either_lo ^ (diff_hi & (either_lo ^ (x2 & x1) ^ (y2 & y1)));
            end
            OP_ADD2: begin
                r.lo = x1;
                r.hi = x2 ^ 1'b1;
            end
            OP_ADD3: begin
                r.lo = x1 ^ 1'b1;
                r.hi = x2 ^ 1'b1;
            end
            default: r = '0;
        endcase
    end

endmodule

// File: rtl/gf4q_lanes.sv
// Replicates the digit lane across a packed vector of DIGITS digits.
// Assumes digit i sits at bits [2i+1:2i] of each vector.
module gf4q_lanes
    import gf4q_pkg::*;
#(
    parameter int DIGITS = 8,
    localparam int W = 2 * DIGITS
) (
    input  gf4_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);

    for (genvar i = 0; i < DIGITS; i++) begin : g_lane
        gf4_digit_t xd, yd, rd;

        // Unpack the lane operands and repack the lane result
        assign xd = a[2*i +: 2];
        assign yd = b[2*i +: 2];
        assign r[2*i +: 2] = rd;

        gf4q_digit_ops u_ops (
            .op (op),
            .x  (xd),
            .y  (yd),
            .r  (rd)
        );
    end

endmodule

// File: rtl/gf4q_hold_reg.sv
// Single-entry output register with valid/ready on both sides.
// Loads when empty or draining; holds while the consumer stalls.
module gf4q_hold_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_valid,
    output logic             load_ready,
    input  logic [WIDTH-1:0] load_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    // Room exists when empty or when the held entry leaves this cycle
    assign load_ready = !out_valid || out_ready;

    // Capture, drain or hold the single result entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load_valid && load_ready) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_ready) |=> (out_valid && out_data == $past(load_data)));

    // R12
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !load_valid) |=> !out_valid);

endmodule

// File: rtl/gf4q_unit.sv
// Quaternary digit field unit: per-digit operation selected by opcode,
// result registered and presented one cycle after acceptance.
module gf4q_unit
    import gf4q_pkg::*;
#(
    parameter int DIGITS = 8,
    localparam int W = 2 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [2:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    localparam logic [W-1:0] HI_MASK = {DIGITS{2'b10}};

    logic [W-1:0] lane_res;
    logic         accept;

    // Handshake completes on the input side
    assign accept = in_valid && in_ready;

    gf4q_lanes #(.DIGITS(DIGITS)) u_lanes (
        .op (gf4_op_e'(in_op)),
        .a  (in_a),
        .b  (in_b),
        .r  (lane_res)
    );

    gf4q_hold_reg #(.WIDTH(W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (in_valid),
        .load_ready (in_ready),
        .load_data  (lane_res),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    // R3
    mul_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_op == 3'd1 && in_a == '0) |=> (out_data == '0));

    // R5
    cube_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_op == 3'd3) |=> ((out_data & HI_MASK) == '0));

    // R6
    min_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_op == 3'd4 && in_a == in_b) |=> (out_data == $past(in_a)));

    // R7
    max_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_op == 3'd5 && in_b == '0) |=> (out_data == $past(in_a)));

endmodule

// File: tb/test_gf4q_unit.sv
`timescale 1ns/1ps
module test_gf4q_unit;

    localparam int DIGITS = 8;
    localparam int W = 2 * DIGITS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_op = '0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    // Reference state
    logic         exp_valid;
    logic [W-1:0] exp_data;
    int           exp_op;

    always #2.5 clk = ~clk;

    gf4q_unit #(.DIGITS(DIGITS)) i_gf4q_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_op     (in_op),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // Polynomial product modulo g^2+g+1 on values 0..3 (R1, R3)
    function automatic int fmul(int p, int q);
        int acc = 0;
        if ((q & 1) != 0) acc = acc ^ p;
        if ((q & 2) != 0) acc = acc ^ (p << 1);
        if ((acc & 4) != 0) acc = acc ^ 7;
        return acc;
    endfunction

    function automatic int digit_ref(int op, int p, int q);
        case (op)
            0: return p ^ q;
            1: return fmul(p, q);
            2: return fmul(p, p);
            3: return fmul(fmul(p, p), p);
            4: return (p < q) ? p : q;
            5: return (p > q) ? p : q;
            6: return p ^ 2;
            default: return p ^ 3;
        endcase
    endfunction

    function automatic logic [W-1:0] vec_ref(int op, logic [W-1:0] va, logic [W-1:0] vb);
        logic [W-1:0] res = '0;
        for (int i = 0; i < DIGITS; i++) begin
            int d = digit_ref(op, int'(va[2*i +: 2]), int'(vb[2*i +: 2]));
            res[2*i +: 2] = d[1:0];
        end
        return res;
    endfunction

    function automatic string req_of(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Cycle model of the handshake and result register (R9, R10, R11, R12)
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_data  <= '0;
            exp_op    <= 0;
        end else if (in_valid && (!exp_valid || out_ready)) begin
            exp_valid <= 1'b1;
            exp_data  <= vec_ref(int'(in_op), in_a, in_b);
            exp_op    <= int'(in_op);
        end else if (out_ready) begin
            exp_valid <= 1'b0;
        end
    end

    task automatic compare();
        logic exp_rdy;
        exp_rdy = !exp_valid || out_ready;
        n_checks++;
        if (out_valid !== exp_valid) begin
            n_fails++;
            $display("FAIL R9/R12 out_valid actual %0b expected %0b", out_valid, exp_valid);
        end
        n_checks++;
        if (in_ready !== exp_rdy) begin
            n_fails++;
            $display("FAIL R10 in_ready actual %0b expected %0b", in_ready, exp_rdy);
        end
        if (exp_valid) begin
            n_checks++;
            if (out_data !== exp_data) begin
                n_fails++;
                $display("FAIL %s (R1 op %0d) out_data actual %h expected %h",
                         req_of(exp_op), exp_op, out_data, exp_data);
            end
        end
    endtask

    // Sample at the falling edge, then drive the next inputs
    task automatic step(logic v, logic [2:0] op, logic [W-1:0] va, logic [W-1:0] vb, logic rdy);
        @(negedge clk);
        compare();
        in_valid  = v;
        in_op     = op;
        in_a      = va;
        in_b      = vb;
        out_ready = rdy;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset clears the register
        n_checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            n_fails++;
            $display("FAIL R11 reset state actual %0b/%h expected 0/0", out_valid, out_data);
        end
        rst_n = 1'b1;

        // Every digit pair through every opcode, output always ready
        for (int op = 0; op < 8; op++) begin
            for (int half = 0; half < 2; half++) begin
                logic [W-1:0] va = '0;
                logic [W-1:0] vb = '0;
                for (int i = 0; i < DIGITS; i++) begin
                    int k = half * DIGITS + i;
                    va[2*i +: 2] = 2'(k >> 2);
                    vb[2*i +: 2] = 2'(k & 3);
                end
                step(1'b1, 3'(op), va, vb, 1'b1);
            end
        end
        step(1'b0, 3'd0, '0, '0, 1'b1);
        step(1'b0, 3'd0, '0, '0, 1'b1);

        // R10: stall with offers pending, then release
        step(1'b1, 3'd1, 16'h1b6c, 16'he4d2, 1'b0);
        for (int c = 0; c < 4; c++) step(1'b1, 3'd4, 16'h5a5a, 16'h3c3c, 1'b0);
        step(1'b1, 3'd5, 16'h0f0f, 16'h9696, 1'b1);
        step(1'b0, 3'd0, '0, '0, 1'b1);

        // Pseudo-random traffic with backpressure
        for (int c = 0; c < 5000; c++) begin
            logic [W-1:0] va = W'($urandom);
            logic [W-1:0] vb = W'($urandom);
            int sel = c % 7;
            if (sel == 1) vb = va;
            if (sel == 3) vb = '0;
            if (sel == 5) va = '0;
            step(($urandom % 4) != 0, 3'($urandom), va, vb, ($urandom % 3) != 0);
        end
        step(1'b0, 3'd0, '0, '0, 1'b1);
        step(1'b0, 3'd0, '0, '0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule